// File: doc/BRIEF.md
# Code-Density Delay-Line Calibration Controller

This controller tunes the four load-adjust codes of an interpolating delay line by code-density statistics. Hits that are not correlated with the reference clock arrive from several channels at once. Each hit carries a decoded 2-bit interpolation code. The controller builds one shared histogram with four bins, one per code. The histogram is pooled over all channels because one set of adjust codes serves every channel.

A start command clears the adjust codes and then runs three ordered phases. Each phase uses the adjust code that feeds its bin:
- Phase one raises the two tail adjusts together until bin 0 reaches about a quarter of the population.
- Phase two raises the middle adjust for bin 1.
- Phase three raises the head adjust for bin 2.

Every adjust change clears the histogram and waits a programmable settling time before hits count again. A phase that drives its code to the maximum without reaching the target ends the run with a failure flag. Hits flagged as invalid patterns are counted apart and never enter a bin.

Top module: `dl_cal_ctrl`

## Requirements
- R1: After reset all adjust codes, bin counts and the invalid-hit count are 0, and busy, done and fail are 0.
- R2: A start while idle sets the four adjust codes to 0. It clears the bins, the invalid-hit count, done and fail, and raises busy. The controller then settles for settle_cfg+1 cycles, during which no hit is counted.
- R3: While collecting, every channel with hit_valid=1 and hit_bad=0 adds one to the bin whose index equals its 2-bit code (hit_code[2c+1:2c] for channel c). Several channels may add in the same cycle.
- R4: A valid hit with hit_bad=1 is counted in bad_cnt and added to no bin.
- R5: Collection stops in the first collecting cycle that begins with the bin total at or above samples_cfg. Hits in that cycle are dropped, and a single evaluation cycle follows.
- R6: The bin under test has reached its target when 4*(bin + tol_cfg) >= total of all bins. Reaching it moves to the next phase one cycle later with the same histogram, and changes no adjust code.
- R7: Phases run in a fixed order. Phase 0 tests bin 0 and steps adj3 and adj4 together (they stay equal). Phase 1 tests bin 1 and steps adj2. Phase 2 tests bin 2 and steps adj1. Each step adds exactly 1.
- R8: An adjust step clears all bins and the total, then settles for settle_cfg+1 cycles before collecting again.
- R9: Reaching the target in phase 2 sets done and clears busy. The adjust codes and bins then hold until the next start.
- R10: Missing the target while the phase's adjust code is at its maximum (15) sets fail and clears busy, with the codes held.
- R11: A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration run (idle only) |
| hit_valid | input | NCH | Per-channel hit strobe |
| hit_code | input | 2*NCH | Per-channel interpolation code, 2 bits each |
| hit_bad | input | NCH | Per-channel invalid-pattern flag |
| samples_cfg | input | CNTW | Hits per histogram |
| tol_cfg | input | CNTW | Tolerance below total/4, in hits |
| settle_cfg | input | SETW | Settling wait after an adjust change |
| adj1 | output | ADJW | Head adjust code |
| adj2 | output | ADJW | Middle adjust code |
| adj3 | output | ADJW | Tail adjust code A |
| adj4 | output | ADJW | Tail adjust code B |
| bin0 | output | CNTW | Count of code 0 |
| bin1 | output | CNTW | Count of code 1 |
| bin2 | output | CNTW | Count of code 2 |
| bin3 | output | CNTW | Count of code 3 |
| bad_cnt | output | CNTW | Invalid hits in this run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run ended with all bins tuned |
| fail | output | 1 | Run ended with a code saturated |

## Verification
Bins and bad_cnt move one cycle after the hits that feed them. An adjust step, a phase advance, done or fail shows one cycle after the evaluation cycle. The evaluation cycle itself comes one cycle after the collecting cycle that sees the total at or above samples_cfg. After a start, collection begins settle_cfg+2 cycles later. A behavioural model in the bench steps through these same latencies on each rising edge. Every output is compared with it on the falling edge, and scenario checks then confirm the final codes and flags.

// File: rtl/dl_cal_ctrl.sv
module dl_cal_ctrl #(
  parameter int NCH  = 8,
  parameter int ADJW = 4,
  parameter int CNTW = 16,
  parameter int SETW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NCH-1:0]    hit_valid,
  input  logic [2*NCH-1:0]  hit_code,
  input  logic [NCH-1:0]    hit_bad,
  input  logic [CNTW-1:0]   samples_cfg,
  input  logic [CNTW-1:0]   tol_cfg,
  input  logic [SETW-1:0]   settle_cfg,
  output logic [ADJW-1:0]   adj1,
  output logic [ADJW-1:0]   adj2,
  output logic [ADJW-1:0]   adj3,
  output logic [ADJW-1:0]   adj4,
  output logic [CNTW-1:0]   bin0,
  output logic [CNTW-1:0]   bin1,
  output logic [CNTW-1:0]   bin2,
  output logic [CNTW-1:0]   bin3,
  output logic [CNTW-1:0]   bad_cnt,
  output logic              busy,
  output logic              done,
  output logic              fail
);
  localparam int CIW = $clog2(NCH + 1) + 2;
  localparam int EW  = CNTW + 3;

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_COLL, S_EVAL} st_t;

  st_t             st;
  logic [1:0]      phase;
  logic [CNTW-1:0] bq [4];
  logic [CNTW-1:0] total;
  logic [SETW-1:0] wait_q;
  logic [CIW-1:0]  inc [4];
  logic [CIW-1:0]  inc_sum, bad_inc;

  always_comb begin
    for (int c = 0; c < 4; c++) inc[c] = '0;
    bad_inc = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      if (hit_valid[ch] && hit_bad[ch]) bad_inc = bad_inc + 1'b1;
      for (int c = 0; c < 4; c++)
        if (hit_valid[ch] && !hit_bad[ch] && hit_code[2*ch +: 2] == 2'(c))
          inc[c] = inc[c] + 1'b1;
    end
    inc_sum = inc[0] + inc[1] + inc[2] + inc[3];
  end

  logic [CNTW-1:0] sel_bin;
  logic [ADJW-1:0] sel_adj;
  logic            reached, at_max, collect_end;

  assign sel_bin = bq[phase];
  assign sel_adj = (phase == 2'd0) ? adj3 : (phase == 2'd1) ? adj2 : adj1;
  assign at_max  = &sel_adj;
  assign reached = ({2'b00, sel_bin, 1'b0} + {2'b00, tol_cfg, 1'b0}) * EW'(2)
                   >= {3'b000, total};
  assign collect_end = total >= samples_cfg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; phase <= '0; total <= '0; wait_q <= '0;
      adj1 <= '0; adj2 <= '0; adj3 <= '0; adj4 <= '0;
      for (int c = 0; c < 4; c++) bq[c] <= '0;
      bad_cnt <= '0; done <= 1'b0; fail <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          adj1 <= '0; adj2 <= '0; adj3 <= '0; adj4 <= '0;
          for (int c = 0; c < 4; c++) bq[c] <= '0;
          total <= '0; bad_cnt <= '0; done <= 1'b0; fail <= 1'b0;
          phase <= '0; wait_q <= settle_cfg; st <= S_SETTLE;
        end
        S_SETTLE: if (wait_q == '0) st <= S_COLL;
                  else wait_q <= wait_q - 1'b1;
        S_COLL: if (collect_end) st <= S_EVAL;
          else begin
            for (int c = 0; c < 4; c++) bq[c] <= bq[c] + CNTW'(inc[c]);
            total   <= total + CNTW'(inc_sum);
            bad_cnt <= bad_cnt + CNTW'(bad_inc);
          end
        S_EVAL: if (reached) begin
            if (phase == 2'd2) begin done <= 1'b1; st <= S_IDLE; end
            else phase <= phase + 1'b1;
          end else if (at_max) begin
            fail <= 1'b1; st <= S_IDLE;
          end else begin
            case (phase)
              2'd0:    begin adj3 <= adj3 + 1'b1; adj4 <= adj4 + 1'b1; end
              2'd1:    adj2 <= adj2 + 1'b1;
              default: adj1 <= adj1 + 1'b1;
            endcase
            for (int c = 0; c < 4; c++) bq[c] <= '0;
            total <= '0; wait_q <= settle_cfg; st <= S_SETTLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy = (st != S_IDLE);
  assign bin0 = bq[0];
  assign bin1 = bq[1];
  assign bin2 = bq[2];
  assign bin3 = bq[3];

  // R7
  tail_pair_chk: assert property (@(posedge clk) disable iff (!rst_n) adj3 == adj4);
  // R7
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adj1 != $past(adj1)) |-> (adj1 == $past(adj1) + 1'b1 || adj1 == '0));
  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({done, fail}));
  // R8
  settle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE) |-> (total == '0));
  // R3
  sum_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {2'b00, bq[0]} + {2'b00, bq[1]} + {2'b00, bq[2]} + {2'b00, bq[3]} == {2'b00, total});
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && !$past(start)) |-> ($stable(adj1) && $stable(adj2) && $stable(bq[0])));
endmodule

// File: tb/tb_dl_cal_ctrl.sv
module tb_dl_cal_ctrl;
  localparam int NCH = 8;
  logic clk = 0, rst_n = 0, start = 0;
  logic [NCH-1:0] hit_valid = '0, hit_bad = '0;
  logic [2*NCH-1:0] hit_code = '0;
  logic [15:0] samples_cfg = 16'd400, tol_cfg = 16'd10;
  logic [11:0] settle_cfg = 12'd3;
  logic [3:0] adj1, adj2, adj3, adj4;
  logic [15:0] bin0, bin1, bin2, bin3, bad_cnt;
  logic busy, done, fail;

  dl_cal_ctrl dut (.clk(clk), .rst_n(rst_n), .start(start), .hit_valid(hit_valid),
    .hit_code(hit_code), .hit_bad(hit_bad), .samples_cfg(samples_cfg), .tol_cfg(tol_cfg),
    .settle_cfg(settle_cfg), .adj1(adj1), .adj2(adj2), .adj3(adj3), .adj4(adj4),
    .bin0(bin0), .bin1(bin1), .bin2(bin2), .bin3(bin3), .bad_cnt(bad_cnt),
    .busy(busy), .done(done), .fail(fail));

  always #4 clk = ~clk;

  integer checks = 0, errors = 0, cyc = 0;
  integer seed = 7, mode = 0, nch_used = 8;

  // reference model
  integer m_st = 0, m_ph = 0, m_tot = 0, m_bad = 0, m_set = 0;
  integer m_a1 = 0, m_a2 = 0, m_a3 = 0, m_a4 = 0, m_done = 0, m_fail = 0;
  integer m_b [4];
  initial for (int i = 0; i < 4; i++) m_b[i] = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_st = 0; m_ph = 0; m_tot = 0; m_bad = 0; m_set = 0; m_done = 0; m_fail = 0;
      m_a1 = 0; m_a2 = 0; m_a3 = 0; m_a4 = 0;
      for (int i = 0; i < 4; i++) m_b[i] = 0;
    end else begin
      case (m_st)
        0: if (start) begin
             m_a1 = 0; m_a2 = 0; m_a3 = 0; m_a4 = 0; m_tot = 0; m_bad = 0;
             for (int i = 0; i < 4; i++) m_b[i] = 0;
             m_done = 0; m_fail = 0; m_ph = 0; m_set = settle_cfg; m_st = 1;
           end
        1: if (m_set == 0) m_st = 2; else m_set = m_set - 1;
        2: if (m_tot >= samples_cfg) m_st = 3;
           else for (int ch = 0; ch < NCH; ch++) if (hit_valid[ch]) begin
             if (hit_bad[ch]) m_bad = m_bad + 1;
             else begin m_b[hit_code[2*ch +: 2]] = m_b[hit_code[2*ch +: 2]] + 1; m_tot = m_tot + 1; end
           end
        default: begin
          if (4 * (m_b[m_ph] + tol_cfg) >= m_tot) begin
            if (m_ph == 2) begin m_done = 1; m_st = 0; end else m_ph = m_ph + 1;
          end else if ((m_ph == 0 ? m_a3 : m_ph == 1 ? m_a2 : m_a1) == 15) begin
            m_fail = 1; m_st = 0;
          end else begin
            if (m_ph == 0) begin m_a3 = m_a3 + 1; m_a4 = m_a4 + 1; end
            else if (m_ph == 1) m_a2 = m_a2 + 1;
            else m_a1 = m_a1 + 1;
            for (int i = 0; i < 4; i++) m_b[i] = 0;
            m_tot = 0; m_set = settle_cfg; m_st = 1;
          end
        end
      endcase
    end
  end

  task automatic chk(input string req, input integer act, input integer exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk("R7 adj1", adj1, m_a1); chk("R7 adj2", adj2, m_a2);
    chk("R7 adj3", adj3, m_a3); chk("R7 adj4", adj4, m_a4);
    chk("R3 bin0", bin0, m_b[0]); chk("R3 bin1", bin1, m_b[1]);
    chk("R3 bin2", bin2, m_b[2]); chk("R3 bin3", bin3, m_b[3]);
    chk("R4 bad_cnt", bad_cnt, m_bad);
    chk("R2 busy", busy, m_st != 0);
    chk("R9 done", done, m_done); chk("R10 fail", fail, m_fail);
    if (m_st == 1) chk("R8 bins empty while settling", bin0 + bin1 + bin2 + bin3, 0);
  end

  // hit source: a toy delay line whose bin widths follow the adjust codes
  always @(negedge clk) begin
    for (int ch = 0; ch < NCH; ch++) begin
      integer r, w0, w1, w2, cd;
      seed = seed * 1103515245 + 12345;
      r = ((seed >>> 8) & 32'h7fff) % 100;
      w0 = 8 + 3 * adj3; w1 = 8 + 2 * adj2 + adj3; w2 = 8 + 2 * adj1 + adj2 + adj3;
      cd = (r < w0) ? 0 : (r < w0 + w1) ? 1 : (r < w0 + w1 + w2) ? 2 : 3;
      if (mode == 1) cd = 3;
      hit_code[2*ch +: 2] = 2'(cd);
      hit_valid[ch] = (ch < nch_used) && (((seed >>> 20) & 3) != 0);
      hit_bad[ch] = (((seed >>> 24) & 15) == 0);
    end
  end

  task automatic run_to_end();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 adj", adj1 + adj2 + adj3 + adj4, 0);
    chk("R1 bins", bin0 + bin1 + bin2 + bin3 + bad_cnt, 0);
    chk("R1 flags", {busy, done, fail}, 0);
    rst_n = 1;
    @(negedge clk);

    // normal run on all channels with a restart attempt mid-run
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    chk("R2 busy after start", busy, 1);
    repeat (30) @(negedge clk);
    begin
      integer b4;
      b4 = bad_cnt;
      start = 1; @(negedge clk); start = 0; @(negedge clk);
      chk("R11 restart ignored busy", busy, 1);
      chk("R11 restart ignored bad kept", bad_cnt >= b4, 1);
    end
    while (busy) @(negedge clk);
    chk("R9 done after tuning", done, 1);
    chk("R7 tail codes moved", adj3 > 0, 1);

    // immediate success with a wide tolerance
    tol_cfg = 16'd400; samples_cfg = 16'd100; settle_cfg = 12'd0;
    run_to_end();
    chk("R6 no adjust change", adj1 + adj2 + adj3 + adj4, 0);
    chk("R5 total reached", (bin0 + bin1 + bin2 + bin3) >= 100, 1);
    chk("R5 total bounded", (bin0 + bin1 + bin2 + bin3) < 100 + NCH, 1);

    // single channel, all hits in code 3: saturate and fail
    mode = 1; nch_used = 1; tol_cfg = 16'd0; samples_cfg = 16'd20; settle_cfg = 12'd2;
    run_to_end();
    chk("R10 fail set", fail, 1);
    chk("R10 tail saturated", adj3, 15);
    chk("R10 head untouched", adj1 + adj2, 0);

    // second normal run with few channels and longer settling
    mode = 0; nch_used = 3; tol_cfg = 16'd8; samples_cfg = 16'd300; settle_cfg = 12'd5;
    run_to_end();
    chk("R9 done second run", done, 1);
    chk("R2 fail cleared by start", fail, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    errors = errors + 1; checks = checks + 1;
    $display("FAIL watchdog actual %0d expected < 190000", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule